// File: doc/BRIEF.md
# Pre-Trigger Capture Sequencer for an On-Chip Logic Analyzer

This block sequences one acquisition of an embedded logic analyzer. Once armed, it writes a packed word of probe values into an external circular sample memory on every storing cycle. It holds back the trigger until a programmed number of pre-trigger samples is in the ring. After the trigger it stores enough further samples to fill the memory, then parks in a finished state that the host polls.

When the capture is finished, the block reports the ring address of the oldest stored sample. The host reads the whole memory, starts at that address, and wraps around to recover time order. Two further modes are available. One stores a sample only on cycles where the trigger input is high. The other ignores the trigger and fills the memory at once.

The sample memory always accepts a write, so the write port has no back-pressure. `write_en` acts as the valid strobe for `write_data` at address `write_ptr`, and it is sampled on the same rising clock edge. The host controls are plain level registers. The block acts only on the 0-to-1 edges of the start and stop controls.

Top module: `la_capture_ctrl`

## Requirements
- R1: After synchronous reset, `state_o` is 0 (idle), `write_en` is 0, and both `read_ptr` and `write_ptr` are 0.
- R2: A capture begins only on a 0-to-1 transition of `req_start` seen while idle. A start level held high does not restart a capture. A new rising edge during a capture neither restarts it nor clears the write pointer.
- R3: A 0-to-1 transition of `req_stop` puts `state_o` back to 0 on the next cycle from any state, even if a start edge arrives in the same cycle. `write_en` is low in idle.
- R4: The states are encoded 0 idle, 1 pre-filling, 2 armed, 3 post-trigger capture, 4 captured. `trig_mode` is encoded 0 single-shot, 1 per-trigger-cycle, 2 immediate. Code 3 behaves as single-shot.
- R5: In single-shot mode with location L > 0, the block spends exactly L cycles in state 1, writing on each of them, and then enters state 2. A trigger pulse during state 1 is ignored. With L = 0 the start edge leads straight to state 2.
- R6: In single-shot mode, the sample written in the first armed cycle with `trig_in` high is the trigger sample. DEPTH−L samples are stored counting that one, and the block then enters state 4. In the rotated buffer, samples are consecutive in time and the trigger sample sits at index L.
- R7: On entry to state 4, `read_ptr` holds the address after the last sample written, which equals `write_ptr`. It is also the oldest sample.
- R8: In per-trigger-cycle mode the start edge leads to state 3. One sample is written on each cycle with `trig_in` high, and the block enters state 4 after DEPTH such samples, with `read_ptr` at 0.
- R9: In immediate mode the start edge leads to state 3. A sample is written on each of the next DEPTH cycles whatever `trig_in` does, and the block then enters state 4.
- R10: `write_en` is high only in states 1, 2 and 3. `write_ptr` advances by one per write, wraps from DEPTH−1 to 0, and is cleared by a start edge.
- R11: `write_data` concatenates all probes, with probe 0 in the most significant bits and probe NPROBE−1 in the least significant bits.
- R12: Trigger mode and trigger location are latched at the start edge. Changing them during a capture has no effect on it. A location of DEPTH or more is treated as DEPTH−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start request; acts on its rising edge |
| req_stop | input | 1 | Abort request; acts on its rising edge |
| trig_mode | input | 2 | 0 single-shot, 1 per-trigger-cycle, 2 immediate, 3 single-shot |
| trig_location | input | $clog2(DEPTH) | Number of pre-trigger samples |
| trig_in | input | 1 | Trigger from the comparator logic |
| probes | input | PROBE_W x NPROBE | Probe values, index 0 is the first probe |
| state_o | output | 3 | Current state code |
| read_ptr | output | $clog2(DEPTH) | Ring address of the oldest sample after capture |
| write_ptr | output | $clog2(DEPTH) | Sample memory write address |
| write_en | output | 1 | Sample memory write strobe |
| write_data | output | NPROBE*PROBE_W | Packed sample word |

## Verification
The bench builds the block with DEPTH 16 and three 8-bit probes. Probe 0 carries a free-running time stamp, so every stored word identifies the cycle it came from. With a 16-entry ring, a 20-cycle armed wait wraps the write pointer, and trigger locations 0, 5 and 15 cover an empty pre-trigger window, an interior one and a single post-trigger sample. The 8-bit stamp cannot alias within one ring, so time order and the trigger position can be checked exactly after rotating by the reported read pointer.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PREFILL = 3'd1,
    ST_ARMED   = 3'd2,
    ST_POST    = 3'd3,
    ST_DONE    = 3'd4
  } cap_state_t;

  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_STEP   = 2'd1,
    MD_NOW    = 2'd2,
    MD_ALT    = 2'd3
  } cap_mode_t;
endpackage

// File: rtl/la_rise_det.sv
module la_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/la_ring_ptr.sv
module la_ring_ptr #(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     adv,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic [$clog2(DEPTH)-1:0] ptr_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign ptr_nxt = (ptr == LAST) ? '0 : ptr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (adv)   ptr <= ptr_nxt;
  end
endmodule

// File: rtl/la_sample_pack.sv
module la_sample_pack #(
  parameter int NPROBE  = 3,
  parameter int PROBE_W = 8
) (
  input  logic [PROBE_W-1:0]        probes [NPROBE],
  output logic [NPROBE*PROBE_W-1:0] word
);
  for (genvar k = 0; k < NPROBE; k++) begin : g_lane
    assign word[(NPROBE-1-k)*PROBE_W +: PROBE_W] = probes[k];
  end
endmodule

// File: rtl/la_cap_fsm.sv
module la_cap_fsm
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_rise,
  input  logic                     stop_rise,
  input  logic [1:0]               mode_in,
  input  logic [$clog2(DEPTH)-1:0] loc_in,
  input  logic                     trig,
  input  logic [$clog2(DEPTH)-1:0] ptr_nxt,
  output cap_state_t               state,
  output logic                     wr_en,
  output logic                     ptr_clr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LOC_MAX = AW'(DEPTH - 1);

  cap_state_t       st_n;
  cap_mode_t        mode_q, mode_n, mode_req;
  logic [AW-1:0]    loc_q, loc_n, loc_c;
  logic [CW-1:0]    cnt, cnt_n, tgt;
  logic [AW-1:0]    rd_n;
  logic             full_run;

  assign mode_req = (cap_mode_t'(mode_in) == MD_ALT) ? MD_SINGLE : cap_mode_t'(mode_in);
  assign loc_c    = (int'(loc_in) > DEPTH - 1) ? LOC_MAX : loc_in;
  assign full_run = (mode_q == MD_STEP) || (mode_q == MD_NOW);
  assign tgt      = full_run ? CW'(DEPTH) : CW'(DEPTH) - CW'(loc_q);

  always_comb begin
    unique case (state)
      ST_PREFILL, ST_ARMED: wr_en = 1'b1;
      ST_POST:              wr_en = (mode_q == MD_STEP) ? trig : 1'b1;
      default:              wr_en = 1'b0;
    endcase
  end

  always_comb begin
    st_n    = state;
    cnt_n   = cnt;
    rd_n    = rd_ptr;
    mode_n  = mode_q;
    loc_n   = loc_q;
    ptr_clr = 1'b0;
    if (stop_rise) begin
      st_n = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (start_rise) begin
          ptr_clr = 1'b1;
          cnt_n   = '0;
          rd_n    = '0;
          mode_n  = mode_req;
          loc_n   = loc_c;
          if (mode_req == MD_STEP || mode_req == MD_NOW) st_n = ST_POST;
          else if (loc_c == '0)                          st_n = ST_ARMED;
          else                                           st_n = ST_PREFILL;
        end
        ST_PREFILL: begin
          if (cnt == CW'(loc_q) - CW'(1)) begin
            st_n  = ST_ARMED;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        ST_ARMED: if (trig) begin
          if (tgt == CW'(1)) begin
            st_n = ST_DONE;
            rd_n = ptr_nxt;
          end else begin
            st_n  = ST_POST;
            cnt_n = CW'(1);
          end
        end
        ST_POST: if (wr_en) begin
          if (cnt == tgt - CW'(1)) begin
            st_n = ST_DONE;
            rd_n = ptr_nxt;
          end else begin
            cnt_n = cnt + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rd_ptr <= '0;
      mode_q <= MD_SINGLE;
      loc_q  <= '0;
    end else begin
      state  <= st_n;
      cnt    <= cnt_n;
      rd_ptr <= rd_n;
      mode_q <= mode_n;
      loc_q  <= loc_n;
    end
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int NPROBE  = 3,
  parameter int PROBE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_start,
  input  logic                        req_stop,
  input  logic [1:0]                  trig_mode,
  input  logic [$clog2(DEPTH)-1:0]    trig_location,
  input  logic                        trig_in,
  input  logic [PROBE_W-1:0]          probes [NPROBE],
  output logic [2:0]                  state_o,
  output logic [$clog2(DEPTH)-1:0]    read_ptr,
  output logic [$clog2(DEPTH)-1:0]    write_ptr,
  output logic                        write_en,
  output logic [NPROBE*PROBE_W-1:0]   write_data
);
  localparam int AW = $clog2(DEPTH);

  logic          start_rise, stop_rise, ptr_clr;
  logic [AW-1:0] ptr_nxt;
  cap_state_t    state;

  la_rise_det u_start (.clk(clk), .rst(rst), .lvl(req_start), .rise(start_rise));
  la_rise_det u_stop  (.clk(clk), .rst(rst), .lvl(req_stop),  .rise(stop_rise));

  la_cap_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst(rst), .start_rise(start_rise), .stop_rise(stop_rise),
    .mode_in(trig_mode), .loc_in(trig_location), .trig(trig_in),
    .ptr_nxt(ptr_nxt), .state(state), .wr_en(write_en),
    .ptr_clr(ptr_clr), .rd_ptr(read_ptr)
  );

  la_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .clr(ptr_clr), .adv(write_en),
    .ptr(write_ptr), .ptr_nxt(ptr_nxt)
  );

  la_sample_pack #(.NPROBE(NPROBE), .PROBE_W(PROBE_W)) u_pack (
    .probes(probes), .word(write_data)
  );

  assign state_o = state;
endmodule

// File: rtl/la_capture_ctrl_chk.sv
module la_capture_ctrl_chk #(
  parameter int DEPTH = 1024
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_start,
  input logic                     req_stop,
  input logic [2:0]               state_o,
  input logic [$clog2(DEPTH)-1:0] read_ptr,
  input logic [$clog2(DEPTH)-1:0] write_ptr,
  input logic                     write_en
);
  localparam int AW = $clog2(DEPTH);

  // R3
  stop_edge_idles_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_stop) |=> state_o == 3'd0);

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && !req_start) |=> state_o == 3'd0);

  // R10
  wen_states_chk: assert property (@(posedge clk) disable iff (rst)
    write_en |-> (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd3));

  // R10
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (write_en && write_ptr == AW'(DEPTH - 1)) |=> write_ptr == '0);

  // R7
  oldest_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd4 |-> read_ptr == write_ptr);

  // R4
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd4);
endmodule

bind la_capture_ctrl la_capture_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req_start(req_start), .req_stop(req_stop),
  .state_o(state_o), .read_ptr(read_ptr), .write_ptr(write_ptr),
  .write_en(write_en)
);

// File: tb/la_capture_ctrl_test.sv
module la_capture_ctrl_test;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_start = 1'b0, req_stop = 1'b0, trig_in = 1'b0;
  logic [1:0]    trig_mode = 2'd0;
  logic [AW-1:0] trig_location = '0;
  logic [7:0]    pr [3];
  logic [7:0]    stamp = 8'd0;
  logic [2:0]    state_o;
  logic [AW-1:0] read_ptr, write_ptr;
  logic          write_en;
  logic [23:0]   write_data;
  logic [23:0]   mem [DEPTH];
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  always_comb begin
    pr[0] = stamp;
    pr[1] = ~stamp;
    pr[2] = 8'hA5;
  end

  always @(posedge clk) begin
    stamp <= stamp + 8'd1;
    if (write_en) mem[write_ptr] <= write_data;
  end

  la_capture_ctrl #(.DEPTH(DEPTH), .NPROBE(3), .PROBE_W(8)) uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_stop(req_stop),
    .trig_mode(trig_mode), .trig_location(trig_location), .trig_in(trig_in),
    .probes(pr), .state_o(state_o), .read_ptr(read_ptr),
    .write_ptr(write_ptr), .write_en(write_en), .write_data(write_data)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int rot(input int i);
    return int'(mem[(int'(read_ptr) + i) % DEPTH][23:16]);
  endfunction

  task automatic stop_capture();
    req_stop = 1'b1;
    step();
    check("R3 stop to idle", int'(state_o), 0);
    check("R3 write_en idle", int'(write_en), 0);
    req_stop = 1'b0;
    step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    check("R1 state", int'(state_o), 0);
    check("R1 write_en", int'(write_en), 0);
    check("R1 read_ptr", int'(read_ptr), 0);
    check("R1 write_ptr", int'(write_ptr), 0);
    step();
  endtask

  task automatic t_pack();
    check("R11 packing", int'(write_data), int'({stamp, ~stamp, 8'hA5}));
  endtask

  task automatic t_single(input int loc, input logic [1:0] md);
    int tgt, bad, rec;
    tgt = DEPTH - loc;
    trig_mode = md;
    trig_location = AW'(loc);
    req_start = 1'b1;
    step();
    req_start = 1'b0;
    trig_location = AW'(3);    // R12 change after start must not matter
    trig_mode = 2'd2;
    check("R4 R5 state after start", int'(state_o), (loc == 0) ? 2 : 1);
    for (int i = 0; i < loc; i++) begin
      check("R5 prefill state", int'(state_o), 1);
      trig_in = (i == 0);
      step();
    end
    trig_in = 1'b0;
    check("R5 armed after prefill", int'(state_o), 2);
    repeat (20) step();
    check("R6 armed waits", int'(state_o), 2);
    trig_in = 1'b1;
    rec = int'(stamp);
    step();
    trig_in = 1'b0;
    for (int k = 0; k < tgt - 1; k++) begin
      check("R6 post state", int'(state_o), 3);
      step();
    end
    check("R6 captured", int'(state_o), 4);
    check("R10 write_en low when done", int'(write_en), 0);
    check("R7 read_ptr", int'(read_ptr), (loc + 20 + tgt) % DEPTH);
    bad = 0;
    for (int i = 0; i < DEPTH - 1; i++)
      if (rot(i + 1) != ((rot(i) + 1) & 255)) bad++;
    check("R6 R12 time order", bad, 0);
    check("R6 trigger index", rot(loc), rec);
    trig_mode = 2'd0;
    stop_capture();
  endtask

  task automatic t_step();
    int exp[DEPTH];
    int bad;
    trig_mode = 2'd1;
    trig_location = AW'(9);
    req_start = 1'b1;
    step();
    req_start = 1'b0;
    check("R8 state after start", int'(state_o), 3);
    for (int n = 0; n < DEPTH; n++) begin
      check("R8 waiting", int'(state_o), 3);
      trig_in = 1'b1;
      exp[n] = int'(stamp);
      step();
      trig_in = 1'b0;
      if (n < DEPTH - 1) repeat (n % 3) step();
    end
    check("R8 captured", int'(state_o), 4);
    check("R8 R7 read_ptr", int'(read_ptr), 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(mem[i][23:16]) != exp[i]) bad++;
    check("R8 stored samples", bad, 0);
    stop_capture();
  endtask

  task automatic t_now();
    int s0, bad;
    trig_mode = 2'd2;
    trig_in = 1'b1;
    s0 = int'(stamp);
    req_start = 1'b1;
    step();
    req_start = 1'b0;
    check("R9 state after start", int'(state_o), 3);
    for (int n = 0; n < DEPTH; n++) begin
      check("R9 filling", int'(state_o), 3);
      trig_in = n[0];
      step();
    end
    trig_in = 1'b0;
    check("R9 captured", int'(state_o), 4);
    check("R9 read_ptr", int'(read_ptr), 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++)
      if (int'(mem[i][23:16]) != ((s0 + 1 + i) & 255)) bad++;
    check("R9 stored samples", bad, 0);
    stop_capture();
  endtask

  task automatic t_edges();
    trig_mode = 2'd0;
    trig_location = AW'(8);
    req_start = 1'b1;
    step();
    check("R2 start edge", int'(state_o), 1);
    req_stop = 1'b1;
    step();
    check("R3 stop with start high", int'(state_o), 0);
    req_stop = 1'b0;
    repeat (5) step();
    check("R2 level does not restart", int'(state_o), 0);
    req_start = 1'b0;
    step();
    req_start = 1'b1;
    step();
    req_start = 1'b0;
    step();
    req_start = 1'b1;
    step();
    req_start = 1'b0;
    check("R2 second edge ignored state", int'(state_o), 1);
    check("R2 R10 pointer not cleared", int'(write_ptr), 2);
    req_stop = 1'b1;
    req_start = 1'b1;
    step();
    check("R3 stop beats start", int'(state_o), 0);
    req_stop = 1'b0;
    req_start = 1'b0;
    step();
  endtask

  initial begin
    t_reset();
    t_pack();
    t_single(5, 2'd0);
    t_single(0, 2'd0);
    t_single(15, 2'd0);
    t_single(7, 2'd3);
    t_step();
    t_now();
    t_edges();
    t_pack();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 100000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule